// File: doc/BRIEF.md
# 15-bit Modular ALU

This unit carries out the arithmetic and logic work of a small virtual-machine core whose values live in a 15-bit space. It has two paths. A combinational path handles equality, unsigned greater-than, addition, multiplication, bitwise AND, bitwise OR and a 15-bit NOT. A sequential path works out the remainder of a division with a restoring divider. The core chooses an operation with a 5-bit select whose codes match the machine's opcode numbers. It supplies two 16-bit operand values and reads back a 16-bit result word.

Addition and multiplication wrap at 32768, not at 65536. NOT inverts only the low 15 bits. Each comparison returns a whole result word holding 0 or 1. The remainder takes several cycles. A one-cycle start pulse loads the operands, and after 16 shift-and-subtract steps a one-cycle done pulse marks the result as valid. The remainder and the zero-divisor flag then stay in place until the next start. A zero divisor sets the flag and forces the remainder to 0.

Top module: `alu15_top`

## Requirements
- R1: With opSel = 9, result equals (opA + opB) mod 32768.
- R2: With opSel = 10, result equals the low 15 bits of opA * opB, with bit 15 cleared.
- R3: With opSel = 4, result is 16'd1 when opA equals opB and 16'd0 otherwise.
- R4: With opSel = 5, result is 16'd1 when opA is strictly greater than opB as an unsigned number and 16'd0 otherwise.
- R5: With opSel = 12, result is opA AND opB over all 16 bits. With opSel = 13, result is opA OR opB over all 16 bits.
- R6: With opSel = 14, result is the complement of opA[14:0], and result[15] is 0.
- R7: Any opSel value other than 4, 5 and 9 to 14 gives a result of 0.
- R8: A start pulse sampled while the divider is idle sets busy from the next cycle. done is high for exactly one cycle, and it rises 16 clock edges after the edge that sampled start.
- R9: From the done cycle until the next accepted start, opSel = 11 presents opA mod opB, using the operands captured at start.
- R10: When the captured divisor is 0, divZero is 1 from the done cycle until the next accepted start, and the opSel = 11 result is 0.
- R11: A start pulse while busy is high is ignored. The running division finishes on its original schedule, using its original operands.
- R12: After reset, busy, done and divZero are 0, and the opSel = 11 result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opSel | input | 5 | Operation select (opcode number) |
| opA | input | 16 | First operand / dividend |
| opB | input | 16 | Second operand / divisor |
| start | input | 1 | One-cycle pulse that launches a remainder computation |
| result | output | 16 | Result word for the selected operation |
| busy | output | 1 | Divider is stepping |
| done | output | 1 | One-cycle pulse: remainder and flag are valid |
| divZero | output | 1 | Captured divisor was zero (valid from done) |

## Verification
The hardest case to reach from the ports is a second start that arrives while a division is still running. The second start carries new operands, including a zero divisor. It could corrupt the captured state or reset the step count, and neither fault shows up until the original done. The stimulus launches a division and then pulses start partway through with different operands. It then checks the timing of done, the remainder and the flag against the first operand pair. Random operand pairs go through both paths, mixed with directed edges: wrap at 32767, the top bit set in the operands, a divisor of one, and a dividend smaller than the divisor.

// File: rtl/alu15_pkg.sv
package alu15_pkg;
  localparam int SEL_W = 5;

  localparam logic [SEL_W-1:0] OP_EQ  = 5'd4;
  localparam logic [SEL_W-1:0] OP_GT  = 5'd5;
  localparam logic [SEL_W-1:0] OP_ADD = 5'd9;
  localparam logic [SEL_W-1:0] OP_MUL = 5'd10;
  localparam logic [SEL_W-1:0] OP_MOD = 5'd11;
  localparam logic [SEL_W-1:0] OP_AND = 5'd12;
  localparam logic [SEL_W-1:0] OP_OR  = 5'd13;
  localparam logic [SEL_W-1:0] OP_NOT = 5'd14;

  // strobes from divider control to divider datapath
  typedef struct packed {
    logic load;    // capture operands, clear partial remainder
    logic step;    // one restoring shift-subtract step
    logic finish;  // last step: mark remainder valid
  } divStrobe_t;

  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_FIN  = 2'd2
  } divState_t;
endpackage

// File: rtl/alu15_comb.sv
module alu15_comb
  import alu15_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VAL_W  = 15
) (
  input  logic [SEL_W-1:0]  opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] combResult,
  output logic              combHit
);
  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] valMask = DATA_W'((1 << VAL_W) - 1);

  logic [DATA_W:0]   sumFull;
  logic [PROD_W-1:0] prodFull;

  assign sumFull  = {1'b0, opA} + {1'b0, opB};
  assign prodFull = PROD_W'(opA) * PROD_W'(opB);

  always_comb begin
    combResult = '0;
    combHit    = 1'b1;
    case (opSel)
      OP_EQ:   combResult = DATA_W'(opA == opB);
      OP_GT:   combResult = DATA_W'(opA > opB);
      OP_ADD:  combResult = sumFull[DATA_W-1:0] & valMask;
      OP_MUL:  combResult = prodFull[DATA_W-1:0] & valMask;
      OP_AND:  combResult = opA & opB;
      OP_OR:   combResult = opA | opB;
      OP_NOT:  combResult = ~opA & valMask;
      default: combHit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu15_divctrl.sv
module alu15_divctrl
  import alu15_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] lastStep = CNT_W'(DATA_W - 1);

  divState_t       state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    case (state)
      DIV_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateNext   = DIV_RUN;
      end
      DIV_RUN: begin
        strobe.step = 1'b1;
        if (stepCnt == lastStep) begin
          strobe.finish = 1'b1;
          stateNext     = DIV_FIN;
        end
      end
      DIV_FIN: stateNext = DIV_IDLE;
      default: stateNext = DIV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= DIV_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.load)      stepCnt <= '0;
      else if (strobe.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state == DIV_RUN);
  assign done = (state == DIV_FIN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R8
  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stepCnt != lastStep) |=> (busy && stepCnt == $past(stepCnt) + 1'b1)); // R11
endmodule

// File: rtl/alu15_divpath.sv
module alu15_divpath
  import alu15_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  divStrobe_t        strobe,
  input  logic [DATA_W-1:0] dividendIn,
  input  logic [DATA_W-1:0] divisorIn,
  output logic [DATA_W-1:0] remOut,
  output logic              divZero
);
  logic [DATA_W-1:0] quoReg, divisorReg, remReg;
  logic              dzReg, validReg;
  logic [DATA_W:0]   trial, trialDiff;
  logic              fits;

  assign trial     = {remReg, quoReg[DATA_W-1]};
  assign trialDiff = trial - {1'b0, divisorReg};
  assign fits      = (trial >= {1'b0, divisorReg});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quoReg     <= '0;
      divisorReg <= '0;
      remReg     <= '0;
      dzReg      <= 1'b0;
      validReg   <= 1'b0;
    end else if (strobe.load) begin
      quoReg     <= dividendIn;
      divisorReg <= divisorIn;
      remReg     <= '0;
      dzReg      <= (divisorIn == '0);
      validReg   <= 1'b0;
    end else if (strobe.step) begin
      remReg <= fits ? trialDiff[DATA_W-1:0] : trial[DATA_W-1:0];
      quoReg <= {quoReg[DATA_W-2:0], fits};
      if (strobe.finish) validReg <= 1'b1;
    end
  end

  assign remOut  = (validReg && !dzReg) ? remReg : '0;
  assign divZero = validReg && dzReg;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (validReg && !dzReg) |-> (remReg < divisorReg)); // R9
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (validReg && !strobe.load) |=> ($stable(remOut) && $stable(divZero))); // R9
endmodule

// File: rtl/alu15_top.sv
module alu15_top
  import alu15_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VAL_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              start,
  output logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              done,
  output logic              divZero
);
  divStrobe_t        divStrobe;
  logic [DATA_W-1:0] combResult, remOut;
  logic              combHit;

  alu15_comb #(.DATA_W(DATA_W), .VAL_W(VAL_W)) i_comb (
    .opSel(opSel), .opA(opA), .opB(opB),
    .combResult(combResult), .combHit(combHit)
  );

  alu15_divctrl #(.DATA_W(DATA_W)) i_divctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strobe(divStrobe), .busy(busy), .done(done)
  );

  alu15_divpath #(.DATA_W(DATA_W)) i_divpath (
    .clk(clk), .rst_n(rst_n), .strobe(divStrobe),
    .dividendIn(opA), .divisorIn(opB),
    .remOut(remOut), .divZero(divZero)
  );

  always_comb begin
    if (opSel == OP_MOD) result = remOut;
    else if (combHit)    result = combResult;
    else                 result = '0;
  end

  AST_NOT_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_NOT) |-> !result[DATA_W-1]); // R6
  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_EQ || opSel == OP_GT) |-> (result[DATA_W-1:1] == '0)); // R3
  AST_WRAP_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_ADD || opSel == OP_MUL) |-> !result[DATA_W-1]); // R1
  AST_DZ_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (divZero && opSel == OP_MOD) |-> (result == '0)); // R10
endmodule

// File: tb/test_alu15_top.sv
module test_alu15_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opSel = '0;
  logic [15:0] opA = '0, opB = '0;
  logic        start = 1'b0;
  logic [15:0] result;
  logic        busy, done, divZero;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alu15_top i_alu15_top (
    .clk(clk), .rst_n(rst_n), .opSel(opSel), .opA(opA), .opB(opB),
    .start(start), .result(result), .busy(busy), .done(done), .divZero(divZero)
  );

  function automatic logic [15:0] expComb(input logic [4:0] s, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    p = {16'd0, a} * {16'd0, b};
    case (s)
      5'd4:  return {15'd0, a == b};
      5'd5:  return {15'd0, a > b};
      5'd9:  return 16'((32'(a) + 32'(b)) % 32768);
      5'd10: return {1'b0, p[14:0]};
      5'd12: return a & b;
      5'd13: return a | b;
      5'd14: return {1'b0, ~a[14:0]};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [4:0] s);
    case (s)
      5'd4: return "R3";  5'd5: return "R4";  5'd9: return "R1";
      5'd10: return "R2"; 5'd12: return "R5"; 5'd13: return "R5";
      5'd14: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic combCheck(input logic [4:0] s, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opSel = s; opA = a; opB = b;
    #1 check(reqOf(s), result, expComb(s, a, b));
  endtask

  // launch at a negedge; checks R8 timing, then R9/R10 values
  task automatic runDivide(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] expRem;
    expRem = (b == 0) ? 16'd0 : a % b;
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy", {15'd0, busy}, 16'd1);
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      if (k == 5) begin
        // R11: restart attempt with other operands while busy
        opA = 16'h7777; opB = (b == 0) ? 16'd3 : 16'd0; start = 1'b1;
      end else start = 1'b0;
      check("R8 early done", {15'd0, done}, 16'd0);
    end
    start = 1'b0;
    @(negedge clk);
    check("R8 done", {15'd0, done}, 16'd1);
    opSel = 5'd11;
    #1 check((b == 0) ? "R10 result" : "R9 R11 remainder", result, expRem);
    check("R10 flag", {15'd0, divZero}, {15'd0, b == 0});
    @(negedge clk);
    check("R8 done width", {15'd0, done}, 16'd0);
    check("R8 busy idle", {15'd0, busy}, 16'd0);
    #1 check("R9 held", result, expRem);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    opSel = 5'd11;
    #1;
    check("R12 busy", {15'd0, busy}, 16'd0);
    check("R12 done", {15'd0, done}, 16'd0);
    check("R12 divZero", {15'd0, divZero}, 16'd0);
    check("R12 result", result, 16'd0);

    // directed corners
    combCheck(5'd9, 16'h7fff, 16'h0001);   // R1 wrap to 0
    combCheck(5'd9, 16'hffff, 16'hffff);   // R1
    combCheck(5'd10, 16'h8000, 16'h0003);  // R2
    combCheck(5'd10, 16'hffff, 16'hffff);  // R2
    combCheck(5'd4, 16'h1234, 16'h1234);   // R3
    combCheck(5'd4, 16'h1234, 16'h1235);   // R3
    combCheck(5'd5, 16'h8000, 16'h7fff);   // R4 unsigned
    combCheck(5'd5, 16'h0005, 16'h0005);   // R4 strict
    combCheck(5'd12, 16'hf0f0, 16'hff00);  // R5
    combCheck(5'd13, 16'h8001, 16'h0100);  // R5
    combCheck(5'd14, 16'h0000, 16'h0000);  // R6
    combCheck(5'd14, 16'hffff, 16'h1234);  // R6
    foreach (opA[i]) begin end
    combCheck(5'd0, 16'hffff, 16'hffff);   // R7
    combCheck(5'd1, 16'h1234, 16'h4321);   // R7
    combCheck(5'd15, 16'hffff, 16'h0001);  // R7
    combCheck(5'd31, 16'hffff, 16'h0001);  // R7

    // random combinational
    for (int i = 0; i < 300; i++) begin
      logic [4:0] s;
      s = 5'($urandom_range(0, 31));
      if (s == 5'd11) s = 5'd9;
      if (i % 2 == 0) s = 5'(($urandom_range(0, 5) == 0) ? 4 : 4 + 0) + 5'($urandom_range(0, 10));
      if (s == 5'd11) s = 5'd14;
      combCheck(s, 16'($urandom), 16'($urandom));
    end

    // remainder corners
    runDivide(16'd100, 16'd7);
    runDivide(16'd5, 16'd0);
    runDivide(16'd3, 16'd9);
    runDivide(16'hffff, 16'h8000);
    runDivide(16'hffff, 16'd1);
    for (int i = 0; i < 20; i++) runDivide(16'($urandom), 16'($urandom_range(1, 65535)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule